// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses for a single read or write burst inside one bank of a synchronous DRAM. A start pulse captures a starting column, a bank number, a burst-length code and an auto-precharge flag. From the next clock onward the block presents one column address per cycle. It stops when the programmed number of beats has been issued or when a terminate input ends the burst.

Fixed-length bursts of 2, 4 or 8 beats step through their aligned block of columns in sequential order and wrap inside it. The column bits above that block do not change. A full-page burst walks the whole row and wraps from the highest column back to zero. It continues until it is terminated or replaced by a new start.

The final beat of a fixed-length burst is marked, so that a command scheduler can issue a self-timed precharge when auto-precharge was requested. A start may arrive on any cycle, including in the middle of a burst. The new start replaces the running burst at once.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After a synchronous reset, `valid_o`, `last_o` and `precharge_o` are all low.
- R2: A cycle with `start_i` high makes `valid_o` high on the next cycle, with `col_o` equal to the sampled `start_col_i` and `bank_o` equal to the sampled `start_bank_i`.
- R3: For bursts of 2, 4 or 8 beats, each following beat's column is the previous column plus one, wrapping within the aligned block of that size. The column bits above the block and `bank_o` stay fixed.
- R4: A fixed-length burst presents exactly its length in consecutive valid beats (1, 2, 4 or 8). `valid_o` falls on the cycle after the final beat unless a new start was sampled.
- R5: `last_o` is high exactly on the final beat of a fixed-length burst. It is never high during a full-page burst.
- R6: Mode code 7 selects a full-page burst. The column increments by one every cycle, wraps from 2^COL_W-1 to 0, and runs without limit.
- R7: `term_i` sampled high during a burst, with `start_i` low, makes `valid_o`, `last_o` and `precharge_o` low on the next cycle. This applies to full-page bursts too.
- R8: A start sampled while a burst is running replaces it on the next cycle. A start takes priority over a terminate sampled in the same cycle.
- R9: `precharge_o` is high exactly when `last_o` is high and the auto-precharge flag sampled with the start was set.
- R10: `term_i` has no effect while no burst is running.
- R11: Length codes are 0→1 beat, 1→2, 2→4, 3→8, 7→full page. Reserved codes 4, 5 and 6 behave as a 1-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a new burst |
| start_col_i | input | COL_W | Starting column, sampled with start |
| start_bank_i | input | BANK_W | Bank, sampled with start |
| len_code_i | input | 3 | Burst-length code, sampled with start |
| auto_pre_i | input | 1 | Auto-precharge request, sampled with start |
| term_i | input | 1 | Ends the running burst |
| valid_o | output | 1 | A column address is being presented |
| col_o | output | COL_W | Current column address |
| bank_o | output | BANK_W | Bank of the current burst |
| last_o | output | 1 | Final beat of a fixed-length burst |
| precharge_o | output | 1 | Precharge request on the final beat |

## Verification
The bench uses the default widths: nine column bits (a 512-column row) and two bank bits. With these widths, a full-page start near column 509 shows the row wrap within a few cycles. Every aligned block of 2, 4 and 8 columns can be reached from random start columns. Directed cases cover:
- mid-block starts that wrap;
- reserved length codes;
- a start and a terminate in the same cycle;
- a terminate while idle.

Random stimulus then mixes restarts, terminates and all length codes.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  typedef logic [2:0] len_code_t;
  localparam len_code_t LEN_FULL_PAGE = 3'd7;
  localparam int        LEN_MAX_LOG   = 3;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  len_code_t        code_i,
  output logic [COL_W-1:0] wrap_mask_o,
  output logic             full_o
);
  always_comb begin
    wrap_mask_o = '0;
    full_o      = 1'b0;
    if (code_i == LEN_FULL_PAGE) begin
      wrap_mask_o = '1;
      full_o      = 1'b1;
    end else if (int'(code_i) <= LEN_MAX_LOG) begin
      for (int b = 0; b < COL_W; b++) begin
        if (b < int'(code_i)) wrap_mask_o[b] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/colgen_next_col.sv
module colgen_next_col #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] mask_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] incr;
  assign incr = col_i + 1'b1;
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? incr[b] : col_i[b];
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [BANK_W-1:0] start_bank_i,
  input  logic [2:0]        len_code_i,
  input  logic              auto_pre_i,
  input  logic              term_i,
  output logic              valid_o,
  output logic [COL_W-1:0]  col_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              last_o,
  output logic              precharge_o
);
  localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

  logic [COL_W-1:0]  dec_mask;
  logic              dec_full;
  logic [COL_W-1:0]  step_col;

  logic              valid_q, last_q, pre_q, full_q, ap_q;
  logic [COL_W-1:0]  col_q, mask_q, left_q;
  logic [BANK_W-1:0] bank_q;

  colgen_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i      (len_code_t'(len_code_i)),
    .wrap_mask_o (dec_mask),
    .full_o      (dec_full)
  );

  colgen_next_col #(.COL_W(COL_W)) u_step (
    .col_i  (col_q),
    .mask_i (mask_q),
    .col_o  (step_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      pre_q   <= 1'b0;
      full_q  <= 1'b0;
      ap_q    <= 1'b0;
      col_q   <= '0;
      mask_q  <= '0;
      left_q  <= '0;
      bank_q  <= '0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      col_q   <= start_col_i;
      bank_q  <= start_bank_i;
      mask_q  <= dec_mask;
      full_q  <= dec_full;
      left_q  <= dec_mask;
      ap_q    <= auto_pre_i;
      last_q  <= !dec_full && (dec_mask == '0);
      pre_q   <= !dec_full && (dec_mask == '0) && auto_pre_i;
    end else if (valid_q) begin
      if (term_i || last_q) begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
        pre_q   <= 1'b0;
      end else begin
        col_q   <= step_col;
        left_q  <= left_q - 1'b1;
        last_q  <= !full_q && (left_q == ONE);
        pre_q   <= !full_q && (left_q == ONE) && ap_q;
      end
    end
  end

  assign valid_o     = valid_q;
  assign col_o       = col_q;
  assign bank_o      = bank_q;
  assign last_o      = last_q;
  assign precharge_o = pre_q;
endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [COL_W-1:0]  start_col_i,
  input logic [BANK_W-1:0] start_bank_i,
  input logic              term_i,
  input logic              valid_o,
  input logic [COL_W-1:0]  col_o,
  input logic [BANK_W-1:0] bank_o,
  input logic              last_o,
  input logic              precharge_o
);
  assert_start_load_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> valid_o && col_o == $past(start_col_i) && bank_o == $past(start_bank_i));

  assert_bank_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !start_i) |=> $stable(bank_o));

  assert_end_after_last_R4: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> !valid_o);

  assert_last_in_burst_R5: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  assert_term_stops_R7: assert property (@(posedge clk) disable iff (rst)
    (term_i && !start_i) |=> !valid_o && !last_o && !precharge_o);

  assert_pre_with_last_R9: assert property (@(posedge clk) disable iff (rst)
    precharge_o |-> last_o);
endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W), .BANK_W(BANK_W)) u_colgen_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .start_col_i  (start_col_i),
  .start_bank_i (start_bank_i),
  .term_i       (term_i),
  .valid_o      (valid_o),
  .col_o        (col_o),
  .bank_o       (bank_o),
  .last_o       (last_o),
  .precharge_o  (precharge_o)
);

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W  = 9;
  localparam int BANK_W = 2;
  localparam int NCOL   = 1 << COL_W;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0, auto_pre_i = 1'b0, term_i = 1'b0;
  logic [COL_W-1:0]  start_col_i = '0;
  logic [BANK_W-1:0] start_bank_i = '0;
  logic [2:0]        len_code_i = '0;
  logic valid_o, last_o, precharge_o;
  logic [COL_W-1:0]  col_o;
  logic [BANK_W-1:0] bank_o;

  int checks = 0, failures = 0;
  bit m_valid = 0, m_ap = 0;
  int m_col = 0, m_bank = 0, m_len = 0, m_left = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W), .BANK_W(BANK_W)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .start_bank_i(start_bank_i), .len_code_i(len_code_i), .auto_pre_i(auto_pre_i),
    .term_i(term_i), .valid_o(valid_o), .col_o(col_o), .bank_o(bank_o),
    .last_o(last_o), .precharge_o(precharge_o)
  );

  // R11: burst length in beats for a code; 0 marks full page
  function automatic int code_len(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int wrap_next(input int col, input int len);
    int base;
    base = col - (col % len);
    return base + ((col % len) + 1) % len;
  endfunction

  task automatic check_bit(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    bit e_last;
    e_last = m_valid && m_len != 0 && m_left == 0;
    check_bit(tag, "valid", int'(valid_o), int'(m_valid));
    check_bit(tag, "last", int'(last_o), int'(e_last));
    check_bit(tag, "precharge", int'(precharge_o), int'(e_last && m_ap));
    if (m_valid) begin
      check_bit(tag, "col", int'(col_o), m_col);
      check_bit(tag, "bank", int'(bank_o), m_bank);
    end
  endtask

  task automatic step(input string tag, input bit s, input int col, input int bank,
                      input int code, input bit ap, input bit t);
    start_i = s; start_col_i = col[COL_W-1:0]; start_bank_i = bank[BANK_W-1:0];
    len_code_i = code[2:0]; auto_pre_i = ap; term_i = t;
    @(posedge clk); #1;
    if (s) begin
      m_valid = 1; m_col = col % NCOL; m_bank = bank; m_len = code_len(code);
      m_left = (m_len == 0) ? 0 : m_len - 1; m_ap = ap;
    end else if (m_valid) begin
      if (t) m_valid = 0;
      else if (m_len == 0) m_col = (m_col + 1) % NCOL;
      else if (m_left == 0) m_valid = 0;
      else begin m_col = wrap_next(m_col, m_len); m_left--; end
    end
    compare(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd7711));
    repeat (3) @(posedge clk);
    #1; rst = 0;
    compare("R1");
    // R3 R4: 8-beat burst starting mid-block at 13 -> 13,14,15,8..12
    step("R2", 1, 13, 2, 3, 0, 0);
    idle("R3", 8);
    // R5 R9: single beat with auto-precharge
    step("R9", 1, 100, 1, 0, 1, 0);
    idle("R5", 2);
    // R4: 4-beat, auto-precharge, start at 6 -> 6,7,4,5
    step("R4", 1, 6, 3, 2, 1, 0);
    idle("R4", 5);
    // R6: full page wraps at the top of the row
    step("R6", 1, NCOL - 3, 0, 7, 1, 0);
    idle("R6", 6);
    // R7: terminate full page
    step("R7", 0, 0, 0, 0, 0, 1);
    idle("R7", 1);
    // R10: terminate while idle
    step("R10", 0, 0, 0, 0, 0, 1);
    idle("R10", 1);
    // R8: restart mid burst, then start together with terminate
    step("R8", 1, 40, 1, 3, 0, 0);
    idle("R8", 2);
    step("R8", 1, 300, 2, 1, 1, 0);
    step("R8", 1, 77, 3, 2, 0, 1);
    idle("R8", 5);
    // R7: terminate a fixed burst early
    step("R7", 1, 200, 0, 3, 1, 0);
    step("R7", 0, 0, 0, 0, 0, 1);
    idle("R7", 1);
    // R11: reserved codes act as one beat
    step("R11", 1, 9, 1, 5, 1, 0);
    idle("R11", 2);
    step("R11", 1, 10, 2, 4, 0, 0);
    step("R11", 1, 11, 3, 6, 1, 0);
    idle("R11", 2);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int codes[6] = '{0, 1, 2, 3, 7, 5};
      bit s, t;
      s = ($urandom % 100) < 15;
      t = ($urandom % 100) < 6;
      step("R3", s, int'($urandom % NCOL), int'($urandom % 4),
           codes[$urandom % 6], bit'($urandom % 2), t);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule